// File: doc/BRIEF.md
# Two-Class Prioritized Interrupt Arbiter

This block picks one winning interrupt line for each of two request classes: a normal class and a fast class. It receives registered per-line vectors for pending state, mask, class selection and a 5-bit urgency level, for one to four banks of 32 lines. Each line is offered to exactly one class. Within a class the most urgent eligible line wins. When levels are equal, the higher line number wins.

Each class arbitrates in one shot. While the class is armed and an eligible line exists, the class raises its request output and latches the winner's code. The class then disarms. The request and the code stay frozen until software strobes that class's agreement input. The strobe drops the request, re-arms the class and evaluates again in the same cycle. A global mask input holds off every new assertion. Reset leaves both classes armed with their requests low.

Top module: `intr_arbiter`

## Requirements
- R1: A line is eligible for the fast class when its pending bit is 1, its mask bit is 0 and its class bit is 1. It is eligible for the normal class under the same pending and mask conditions with a class bit of 0. A masked or non-pending line never wins.
- R2: Among the eligible lines of one class, the line with the numerically smallest level wins. Level 0 is the most urgent.
- R3: When several eligible lines share the best level, the line with the highest index wins.
- R4: The code output equals 32 × bank + bit position. This is the flat line index, and line k uses bits [5k+4:5k] of the level vector.
- R5: A class's request rises one clock edge after an edge at which three conditions hold together: the class is armed, at least one line of the class is eligible, and the global mask is 0. At that edge the winner's code is latched and the class disarms. A global mask of 1 blocks the assertion.
- R6: While a class's request is high and its strobe is 0, the request stays high and the code stays fixed, whatever the line inputs do.
- R7: A strobe on a class drops its request and re-arms it. In that same edge, the class re-evaluates and re-asserts with a new code if the R5 conditions hold. Otherwise the request stays low until they hold.
- R8: After reset both requests are 0, both codes are 0, and both classes are armed.
- R9: While a class's request is low, its code keeps its previous value.
- R10: The two classes arm, assert and latch independently. A strobe on one class leaves the other class's outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_pend | input | NUM_BANKS×32 | Per-line pending bits |
| line_mask | input | NUM_BANKS×32 | Per-line mask bits (1 = masked) |
| line_fast | input | NUM_BANKS×32 | Per-line class select (1 = fast, 0 = normal) |
| line_level | input | NUM_BANKS×32×5 | Per-line urgency level, 0 most urgent |
| glob_mask | input | 1 | 1 blocks every new assertion |
| agree_norm | input | 1 | Normal-class re-arm strobe |
| agree_fast | input | 1 | Fast-class re-arm strobe |
| req_norm | output | 1 | Normal-class request |
| code_norm | output | clog2(NUM_BANKS×32) | Latched normal-class winner |
| req_fast | output | 1 | Fast-class request |
| code_fast | output | clog2(NUM_BANKS×32) | Latched fast-class winner |

## Verification
A wrong winner selection or a wrong eligibility decision shows at the code outputs. It appears one edge after the arming strobe or after the first eligible line. A stuck or lost armed flag shows as a request that never rises once lines become eligible, or as one that rises again without a strobe. Either shows within a cycle of the triggering event. A code register that updates while it should be frozen shows as a code change with no rise of the request.

// File: rtl/intr_arb_pkg.sv
package intr_arb_pkg;
  localparam int LINES_PER_BANK = 32;
  localparam int LEVEL_W        = 5;
  localparam int NUM_CLASSES    = 2;
  typedef enum logic {CLS_NORM = 1'b0, CLS_FAST = 1'b1} cls_e;
endpackage

// File: rtl/arb_tree.sv
// Combinational winner search: lowest level first, higher index on ties.
module arb_tree #(
  parameter int N       = 64,
  parameter int LEVEL_W = 5,
  parameter int IDX_W   = 6
) (
  input  logic [N-1:0]         elig,
  input  logic [N*LEVEL_W-1:0] level,
  output logic                 any,
  output logic [IDX_W-1:0]     win
);
  localparam int P     = 1 << $clog2(N);
  localparam int NODES = 2 * P - 1;

  logic               nv [NODES];
  logic [LEVEL_W-1:0] nl [NODES];
  logic [IDX_W-1:0]   ni [NODES];

  always_comb begin
    for (int k = 0; k < P; k++) begin
      if (k < N) begin
        nv[P-1+k] = elig[k];
        nl[P-1+k] = level[k*LEVEL_W +: LEVEL_W];
      end else begin
        nv[P-1+k] = 1'b0;
        nl[P-1+k] = '1;
      end
      ni[P-1+k] = IDX_W'(k);
    end
    for (int i = P - 2; i >= 0; i--) begin
      // right child holds the higher indices; it wins ties
      if (nv[2*i+2] && (!nv[2*i+1] || (nl[2*i+2] <= nl[2*i+1]))) begin
        nv[i] = 1'b1;
        nl[i] = nl[2*i+2];
        ni[i] = ni[2*i+2];
      end else begin
        nv[i] = nv[2*i+1];
        nl[i] = nl[2*i+1];
        ni[i] = ni[2*i+1];
      end
    end
  end

  assign any = nv[0];
  assign win = ni[0];
endmodule

// File: rtl/class_arbiter.sv
// One-shot arm / fire / latch sequencer for one request class.
module class_arbiter #(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              any,
  input  logic [CODE_W-1:0] win,
  input  logic              glob_mask,
  input  logic              agree,
  output logic              req,
  output logic [CODE_W-1:0] code
);
  logic armed_q, armed_d;
  logic req_q, req_d;
  logic [CODE_W-1:0] code_q;
  logic fire;

  always_comb begin
    fire    = (armed_q | agree) & any & ~glob_mask;
    armed_d = armed_q;
    req_d   = req_q;
    if (agree) begin
      armed_d = 1'b1;
      req_d   = 1'b0;
    end
    if (fire) begin
      armed_d = 1'b0;
      req_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      req_q   <= 1'b0;
    end else begin
      armed_q <= armed_d;
      req_q   <= req_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    code_q <= '0;
    else if (fire) code_q <= win;
  end

  assign req  = req_q;
  assign code = code_q;
endmodule

// File: rtl/intr_arbiter.sv
module intr_arbiter
  import intr_arb_pkg::*;
#(
  parameter int NUM_BANKS = 2
) (
  input  logic                                               clk,
  input  logic                                               rst_n,
  input  logic [NUM_BANKS*LINES_PER_BANK-1:0]                line_pend,
  input  logic [NUM_BANKS*LINES_PER_BANK-1:0]                line_mask,
  input  logic [NUM_BANKS*LINES_PER_BANK-1:0]                line_fast,
  input  logic [NUM_BANKS*LINES_PER_BANK*LEVEL_W-1:0]        line_level,
  input  logic                                               glob_mask,
  input  logic                                               agree_norm,
  input  logic                                               agree_fast,
  output logic                                               req_norm,
  output logic [$clog2(NUM_BANKS*LINES_PER_BANK)-1:0]        code_norm,
  output logic                                               req_fast,
  output logic [$clog2(NUM_BANKS*LINES_PER_BANK)-1:0]        code_fast
);
  localparam int NL     = NUM_BANKS * LINES_PER_BANK;
  localparam int CODE_W = $clog2(NL);

  logic [NL-1:0]     elig  [NUM_CLASSES];
  logic              agree [NUM_CLASSES];
  logic              any   [NUM_CLASSES];
  logic [CODE_W-1:0] win   [NUM_CLASSES];
  logic              req   [NUM_CLASSES];
  logic [CODE_W-1:0] code  [NUM_CLASSES];

  assign elig[CLS_NORM]  = line_pend & ~line_mask & ~line_fast;
  assign elig[CLS_FAST]  = line_pend & ~line_mask &  line_fast;
  assign agree[CLS_NORM] = agree_norm;
  assign agree[CLS_FAST] = agree_fast;

  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
    arb_tree #(.N(NL), .LEVEL_W(LEVEL_W), .IDX_W(CODE_W)) u_tree (
      .elig (elig[c]),
      .level(line_level),
      .any  (any[c]),
      .win  (win[c])
    );
    class_arbiter #(.CODE_W(CODE_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .any      (any[c]),
      .win      (win[c]),
      .glob_mask(glob_mask),
      .agree    (agree[c]),
      .req      (req[c]),
      .code     (code[c])
    );
  end

  assign req_norm  = req[CLS_NORM];
  assign code_norm = code[CLS_NORM];
  assign req_fast  = req[CLS_FAST];
  assign code_fast = code[CLS_FAST];
endmodule

// File: rtl/intr_arb_chk.sv
module intr_arb_chk #(
  parameter int CODE_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              glob_mask,
  input logic              agree_norm,
  input logic              agree_fast,
  input logic              req_norm,
  input logic [CODE_W-1:0] code_norm,
  input logic              req_fast,
  input logic [CODE_W-1:0] code_fast
);
  // R5: a rising request needs the global mask clear at the firing edge
  a_r5_norm_gmask: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_norm) |-> $past(!glob_mask));
  a_r5_fast_gmask: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_fast) |-> $past(!glob_mask));
  // R6: request held until a strobe
  a_r6_norm_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_norm && !agree_norm) |=> req_norm);
  a_r6_fast_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fast && !agree_fast) |=> req_fast);
  // R9: code frozen while request low
  a_r9_norm_code: assert property (@(posedge clk) disable iff (!rst_n)
    !req_norm |-> $stable(code_norm));
  a_r9_fast_code: assert property (@(posedge clk) disable iff (!rst_n)
    !req_fast |-> $stable(code_fast));
  // R8: requests low under reset
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r8_reset_low: assert (!req_norm && !req_fast);
    end
  end
endmodule

bind intr_arbiter intr_arb_chk #(.CODE_W(CODE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .glob_mask (glob_mask),
  .agree_norm(agree_norm),
  .agree_fast(agree_fast),
  .req_norm  (req_norm),
  .code_norm (code_norm),
  .req_fast  (req_fast),
  .code_fast (code_fast)
);

// File: tb/intr_arbiter_tb.sv
module intr_arbiter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NB  = 2;
  localparam int NL  = NB * 32;
  localparam int LW  = 5;
  localparam int CW  = $clog2(NL);

  logic clk = 1'b0;
  logic rst_n;
  logic [NL-1:0]    pend, mask, fast;
  logic [NL*LW-1:0] lvl;
  logic gm, agn, agf;
  logic req_n, req_f;
  logic [CW-1:0] code_n, code_f;
  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intr_arbiter #(.NUM_BANKS(NB)) u_dut (
    .clk(clk), .rst_n(rst_n), .line_pend(pend), .line_mask(mask),
    .line_fast(fast), .line_level(lvl), .glob_mask(gm),
    .agree_norm(agn), .agree_fast(agf),
    .req_norm(req_n), .code_norm(code_n), .req_fast(req_f), .code_fast(code_f)
  );

  typedef struct packed {
    logic [6:0] l0; logic [4:0] p0; logic c0;
    logic [6:0] l1; logic [4:0] p1; logic c1;
    logic [6:0] l2; logic [4:0] p2; logic c2;
    logic rn; logic [6:0] cn; logic rf; logic [6:0] cf;
  } vec_t;

  // line, level, class(1=fast) x3 ; expected norm req/code, fast req/code
  localparam vec_t TBL [5] = '{
    '{7'd5,  5'd3, 1'b0, 7'd40, 5'd3, 1'b1, 7'd7,  5'd2,  1'b0, 1'b1, 7'd7,  1'b1, 7'd40},
    '{7'd3,  5'd4, 1'b0, 7'd60, 5'd4, 1'b0, 7'd33, 5'd9,  1'b1, 1'b1, 7'd60, 1'b1, 7'd33},
    '{7'd0,  5'd0, 1'b1, 7'd63, 5'd1, 1'b1, 7'd10, 5'd31, 1'b0, 1'b1, 7'd10, 1'b1, 7'd0},
    '{7'd20, 5'd5, 1'b1, 7'd21, 5'd5, 1'b1, 7'd50, 5'd6,  1'b1, 1'b0, 7'd10, 1'b1, 7'd21},
    '{7'd32, 5'd7, 1'b0, 7'd31, 5'd7, 1'b0, 7'd1,  5'd7,  1'b1, 1'b1, 7'd32, 1'b1, 7'd1}
  };

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_line(input int l, input int p, input logic c);
    pend[l] = 1'b1;
    fast[l] = c;
    lvl[l*LW +: LW] = LW'(p);
  endtask

  task automatic clear_lines;
    pend = '0;
    fast = '0;
    lvl  = '1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; gm = 1'b0; agn = 1'b0; agf = 1'b0;
    mask = '0;
    clear_lines();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    // R8 reset state
    check("R8 req_norm", int'(req_n), 0);
    check("R8 req_fast", int'(req_f), 0);
    check("R8 code_norm", int'(code_n), 0);
    check("R8 code_fast", int'(code_f), 0);

    // R8/R5: armed out of reset, fires without strobe
    set_line(9, 1, 1'b0);
    tick();
    check("R5 req_norm armed", int'(req_n), 1);
    check("R4 code_norm", int'(code_n), 9);

    // R6: frozen against input change
    pend[9] = 1'b0;
    set_line(12, 0, 1'b0);
    tick(); tick();
    check("R6 req_norm held", int'(req_n), 1);
    check("R6 code_norm frozen", int'(code_n), 9);

    // R1: masked line skipped; R10 fast fires on its own
    mask[12] = 1'b1;
    set_line(4, 9, 1'b0);
    set_line(13, 0, 1'b1);
    agn = 1'b1;
    tick();
    agn = 1'b0;
    check("R1 masked skipped code_norm", int'(code_n), 4);
    check("R1 fast class req_fast", int'(req_f), 1);
    check("R1 fast class code_fast", int'(code_f), 13);

    // R5: global mask blocks; R7 drop; R9 code kept
    gm = 1'b1;
    agn = 1'b1;
    tick();
    agn = 1'b0;
    check("R7 req_norm dropped", int'(req_n), 0);
    check("R9 code_norm kept", int'(code_n), 4);
    mask[12] = 1'b0;
    tick();
    check("R5 gmask blocks req_norm", int'(req_n), 0);
    check("R6 req_fast held under gmask", int'(req_f), 1);
    gm = 1'b0;
    tick();
    check("R5 req_norm after gmask clear", int'(req_n), 1);
    check("R2 code_norm after gmask clear", int'(code_n), 12);

    // R7/R10: strobe fast with nothing eligible
    clear_lines();
    agf = 1'b1;
    tick();
    agf = 1'b0;
    check("R7 req_fast dropped", int'(req_f), 0);
    check("R10 req_norm untouched", int'(req_n), 1);
    check("R10 code_norm untouched", int'(code_n), 12);
    set_line(50, 2, 1'b1);
    tick();
    check("R7 req_fast rearmed", int'(req_f), 1);
    check("R4 code_fast bank1", int'(code_f), 50);

    // table walk: R2 R3 R4 R7 R9
    for (int e = 0; e < 5; e++) begin
      clear_lines();
      set_line(int'(TBL[e].l0), int'(TBL[e].p0), TBL[e].c0);
      set_line(int'(TBL[e].l1), int'(TBL[e].p1), TBL[e].c1);
      set_line(int'(TBL[e].l2), int'(TBL[e].p2), TBL[e].c2);
      agn = 1'b1; agf = 1'b1;
      tick();
      agn = 1'b0; agf = 1'b0;
      check("R7 table req_norm", int'(req_n), int'(TBL[e].rn));
      check("R3 table code_norm", int'(code_n), int'(TBL[e].cn));
      check("R7 table req_fast", int'(req_f), int'(TBL[e].rf));
      check("R2 table code_fast", int'(code_f), int'(TBL[e].cf));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule